// File: doc/BRIEF.md
# Dual-Purpose Line Relay Guard

This block drives a normally-open solid-state relay that sits between a front-panel line, shared by an analog time-code receiver and digital logic, and the digital circuitry behind it. The relay is closed only while some digital use of the line is active. Five status inputs report those uses: the line is a route source, the line is a route destination, edge timestamping on the line is on, timed events or clocks are scheduled out of the line, or the level-coded time-code format is the selected time reference.

The relay needs a fixed time to change state (5 ms). While it is closing, the block masks the line's edge timestamps as invalid and forces the line's output driver low. Only after a full settle count with the relay still commanded closed does it raise a settled flag, unmask timestamps and release the driver. If the digital use ends, the relay opens. An open transition is also timed with the same count. The relay is not allowed to close again until that open transition is complete.

The sequencer has four named states. OPEN_IDLE holds the relay open. CLOSING drives the relay while the settle count runs. CLOSED means the relay is settled. OPENING releases the relay while the settle count runs. The transitions are: OPEN_IDLE to CLOSING when a use appears; CLOSING to CLOSED when the count expires with a use still present; CLOSING or CLOSED to OPENING when all uses vanish; OPENING to OPEN_IDLE when the count expires.

Top module: `line_relay_guard`

## Requirements
- R1: Each of the five use inputs, asserted on its own with the others low, closes the relay and leads to the settled state.
- R2: After reset the outputs are as follows: relay_close_o is 0, settled_o is 0, stamp_valid_o is 0 and out_force_low_o is 1.
- R3: When the block is open and idle and a use is present at a clock edge, relay_close_o is 1 from that edge onward. When no use is present at a clock edge, relay_close_o is 0 from that edge onward.
- R4: When a use is held, settled_o rises exactly SETTLE_CYCLES clock cycles after relay_close_o rises.
- R5: When all uses drop, the relay enters an opening window of SETTLE_CYCLES cycles with relay_close_o at 0. This applies whether the relay was closing or settled. settled_o stays 0 during the window. The relay closes again no earlier than one cycle after the window ends.
- R6: stamp_valid_o is 1 exactly when settled_o is 1. It is never 1 unless a use was present at the preceding edge.
- R7: out_force_low_o is 1 whenever settled_o is 0, and in particular whenever the relay is not commanded closed.
- R8: While the block is settled, changes in which uses are active have no effect on any output, as long as at least one use stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| route_src_i | input | 1 | Line is the source of a signal route |
| route_dst_i | input | 1 | Line is the destination of a signal route |
| stamp_en_i | input | 1 | Edge timestamping on the line is enabled |
| sched_out_i | input | 1 | Timed events or clocks are scheduled out of the line |
| dc_ref_i | input | 1 | Level-coded time code is the selected time reference |
| relay_close_o | output | 1 | 1 commands the relay closed |
| settled_o | output | 1 | Relay is closed and its settle time has elapsed |
| stamp_valid_o | output | 1 | Timestamps from the line may be kept |
| out_force_low_o | output | 1 | Hold the line's output driver low |

## Verification
The five use inputs are driven one at a time. This shows that each use alone closes the relay and that the settle interval is exactly the parameter count. Random slow toggling of all five inputs is then compared against a bench reference model every cycle. This random stimulus produces use drops during CLOSING and during CLOSED, use returns during OPENING, and swaps between uses while settled. It therefore separates a correct restart of the count from a count that is carried over or skipped. Directed cases drop the use in the middle of a close and re-request it in the middle of an open. These cases confirm the opening window and the ban on early reclosing.

// File: rtl/line_relay_guard_pkg.sv
package line_relay_guard_pkg;
    typedef enum logic [1:0] {
        OPEN_IDLE = 2'd0,
        CLOSING   = 2'd1,
        CLOSED    = 2'd2,
        OPENING   = 2'd3
    } guard_state_t;

    localparam int unsigned NUM_USES = 5;
endpackage

// File: rtl/lrg_use_detect.sv
module lrg_use_detect
    import line_relay_guard_pkg::*;
(
    input  logic [NUM_USES-1:0] uses_i,
    output logic                want_o
);
    // Digital use of the line is the OR of every reported use (R1)
    assign want_o = |uses_i;
endmodule

// File: rtl/lrg_settle_timer.sv
module lrg_settle_timer #(
    parameter int unsigned SETTLE_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic zero_o
);
    localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load_i) begin
            remain_q <= RELOAD;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign zero_o = (remain_q == '0);
endmodule

// File: rtl/lrg_sequencer.sv
module lrg_sequencer
    import line_relay_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    input  logic zero_i,
    output logic load_o,
    output logic relay_close_o,
    output logic settled_o,
    output logic stamp_valid_o,
    output logic out_force_low_o
);
    guard_state_t state_q, state_d;

    // Next state and timer reload
    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        unique case (state_q)
            OPEN_IDLE: begin
                if (want_i) begin
                    state_d = CLOSING;
                    load_o  = 1'b1;
                end
            end
            CLOSING: begin
                if (!want_i) begin
                    state_d = OPENING;
                    load_o  = 1'b1;
                end else if (zero_i) begin
                    state_d = CLOSED;
                end
            end
            CLOSED: begin
                if (!want_i) begin
                    state_d = OPENING;
                    load_o  = 1'b1;
                end
            end
            OPENING: begin
                if (zero_i) begin
                    state_d = OPEN_IDLE;
                end
            end
            default: state_d = OPEN_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OPEN_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from state
    always_comb begin
        relay_close_o   = 1'b0;
        settled_o       = 1'b0;
        stamp_valid_o   = 1'b0;
        out_force_low_o = 1'b1;
        unique case (state_q)
            OPEN_IDLE: ;
            CLOSING:   relay_close_o = 1'b1;
            CLOSED: begin
                relay_close_o   = 1'b1;
                settled_o       = 1'b1;
                stamp_valid_o   = 1'b1;
                out_force_low_o = 1'b0;
            end
            OPENING:   ;
            default:   ;
        endcase
    end
endmodule

// File: rtl/line_relay_guard.sv
module line_relay_guard
    import line_relay_guard_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic route_src_i,
    input  logic route_dst_i,
    input  logic stamp_en_i,
    input  logic sched_out_i,
    input  logic dc_ref_i,
    output logic relay_close_o,
    output logic settled_o,
    output logic stamp_valid_o,
    output logic out_force_low_o
);
    logic want;
    logic load;
    logic zero;

    lrg_use_detect u_detect (
        .uses_i ({dc_ref_i, sched_out_i, stamp_en_i, route_dst_i, route_src_i}),
        .want_o (want)
    );

    lrg_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .zero_o (zero)
    );

    lrg_sequencer u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .want_i          (want),
        .zero_i          (zero),
        .load_o          (load),
        .relay_close_o   (relay_close_o),
        .settled_o       (settled_o),
        .stamp_valid_o   (stamp_valid_o),
        .out_force_low_o (out_force_low_o)
    );
endmodule

// File: rtl/line_relay_guard_checker.sv
module line_relay_guard_checker #(
    parameter int unsigned SETTLE_CYCLES = 1_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic route_src_i,
    input logic route_dst_i,
    input logic stamp_en_i,
    input logic sched_out_i,
    input logic dc_ref_i,
    input logic relay_close_o,
    input logic settled_o,
    input logic stamp_valid_o,
    input logic out_force_low_o
);
    localparam int unsigned CW = $clog2(SETTLE_CYCLES + 3);
    localparam logic [CW-1:0] SAT = CW'(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] EXP = CW'(SETTLE_CYCLES);

    logic any_use;
    logic [CW-1:0] close_run_q;

    assign any_use = route_src_i | route_dst_i | stamp_en_i | sched_out_i | dc_ref_i;

    // Cycles spent commanded closed but not yet settled
    always_ff @(posedge clk) begin
        if (!rst_n || !relay_close_o) close_run_q <= '0;
        else if (!settled_o && close_run_q != SAT) close_run_q <= close_run_q + 1'b1;
    end

    assert_drop_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !any_use |=> !relay_close_o);

    assert_settle_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled_o) |-> close_run_q == EXP);

    assert_settled_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        settled_o |-> relay_close_o);

    assert_stamp_needs_use_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_valid_o |-> $past(any_use));

    assert_stamp_not_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_valid_o |-> !out_force_low_o);

    assert_open_forces_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !relay_close_o |-> out_force_low_o);
endmodule

bind line_relay_guard line_relay_guard_checker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (.*);

// File: tb/sim_line_relay_guard.sv
`timescale 1ns/1ps
module sim_line_relay_guard;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] uses = '0;
    logic relay, settled, svalid, flow;

    int checks = 0;
    int fails = 0;
    int ph = 0;
    int left = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    line_relay_guard #(.SETTLE_CYCLES(N)) u0 (
        .clk(clk), .rst_n(rst_n),
        .route_src_i(uses[0]), .route_dst_i(uses[1]), .stamp_en_i(uses[2]),
        .sched_out_i(uses[3]), .dc_ref_i(uses[4]),
        .relay_close_o(relay), .settled_o(settled),
        .stamp_valid_o(svalid), .out_force_low_o(flow)
    );

    // Reference model: 0 open, 1 closing, 2 settled, 3 opening
    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; left = 0;
        end else begin
            case (ph)
                0: if (|uses) begin ph = 1; left = N - 1; end
                1: if (!(|uses)) begin ph = 3; left = N - 1; end
                   else if (left == 0) ph = 2; else left = left - 1;
                2: if (!(|uses)) begin ph = 3; left = N - 1; end
                default: if (left == 0) ph = 0; else left = left - 1;
            endcase
        end
    end

    function automatic bit exp_relay(int p); return (p == 1 || p == 2); endfunction
    function automatic bit exp_settled(int p); return (p == 2); endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison with the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 relay_close", relay, exp_relay(ph));
            check("R5 settled", settled, exp_settled(ph));
            check("R6 stamp_valid", svalid, exp_settled(ph));
            check("R7 force_low", flow, !exp_settled(ph));
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_open();
        uses = '0;
        cycles(N + 3);
    endtask

    initial begin
        int cnt;
        cycles(3);
        check("R2 reset relay", relay, 1'b0);
        check("R2 reset settled", settled, 1'b0);
        check("R2 reset stamp_valid", svalid, 1'b0);
        check("R2 reset force_low", flow, 1'b1);
        rst_n = 1'b1;
        cycles(2);

        // R1 and R4: each use alone, settle count measured at the ports
        for (int b = 0; b < 5; b++) begin
            uses = 5'b1 << b;
            cycles(1);
            check("R3 relay rises", relay, 1'b1);
            cnt = 0;
            while (!settled && cnt < 4 * N) begin cycles(1); cnt++; end
            checks++;
            if (cnt != N) begin
                fails++;
                $display("FAIL R4 settle cycles actual=%0d expected=%0d", cnt, N);
            end
            check("R1 use alone settles", settled, 1'b1);
            go_open();
        end

        // R5: drop mid-close, then re-request mid-open
        uses = 5'b00100;
        cycles(N / 2);
        uses = '0;
        cycles(1);
        check("R5 drop mid-close opens", relay, 1'b0);
        cycles(N / 2);
        uses = 5'b01000;
        cycles(N / 2 - 1);
        check("R5 no early reclose", relay, 1'b0);
        cnt = 0;
        while (!relay && cnt < 4 * N) begin cycles(1); cnt++; end
        check("R5 recloses after window", relay, 1'b1);
        cycles(N + 1);
        check("R5 settles after reclose", settled, 1'b1);

        // R8: swap uses while settled
        uses = 5'b10000;
        cycles(3);
        uses = 5'b00011;
        cycles(3);
        check("R8 swap keeps settled", settled, 1'b1);
        check("R8 swap keeps force_low off", flow, 1'b0);
        go_open();

        // Random slow toggling against the model
        void'($urandom(32'h5EED_0017));
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 19) == 0) uses[$urandom_range(0, 4)] ^= 1'b1;
            if ($urandom_range(0, 199) == 0) uses = '0;
            cycles(1);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(5 * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule